// File: doc/BRIEF.md
# Multi-Slot Interrupt Status Controller

This block gathers interrupt requests from a set of plug-in module slots, each slot offering two request lines, and folds them into a single host interrupt. Every slot owns an 8-bit control register that enables each of its lines and picks edge or level behaviour for it. A shared 16-bit status word records the line states and the per-slot timeout flags. Software reaches both through a simple 16-bit register port with a one-cycle registered read.

A level-mode line keeps the host interrupt asserted for as long as its status bit is set. An edge-mode line instead inverts the host interrupt for exactly one cycle when its request rises. Software clears module requests in two ways. It can write ones to the status word, or it can read a slot's interrupt space at offset 0 or 2. Either action produces a one-cycle clear strobe towards the module. Strobes go only to slots flagged as populated.

Top module: `slotirq_ctrl`

## Requirements
- R1: After a synchronous reset, every control register, the status word, `host_irq`, `req_clear` and `reg_rdata` are zero.
- R2: A read returns its data on `reg_rdata` in the cycle after `reg_rd_en`, and `reg_rdata` is zero in any cycle not preceded by a read. Address 0x00 (revision) and 0x0A (reset word) read 0x0000 and ignore writes. Odd or unmapped addresses read zero.
- R3: The control register of slot s sits at byte address 2*(s+1) (0x02, 0x04, 0x06, 0x08). A write stores `reg_wdata[7:0]`, and a read returns it zero-extended. Bit 6+n enables line n and bit 4+n selects edge mode for line n. Bits 3:0 are stored with no behaviour.
- R4: While the enable bit of a line is clear, a change on its request neither updates its status bit nor affects `host_irq`.
- R5: For an enabled line of slot s, status bit 2*s+n (status at address 0x0C) follows the request level. It updates on the clock edge that samples the request.
- R6: When an enabled edge-mode line's request rises from a cleared status bit, `host_irq` shows the inverse of its held level for exactly one cycle. A falling edge-mode request leaves `host_irq` unchanged.
- R7: The held level of `host_irq` is the OR of all status bits whose line is in level mode. Edge-mode status bits are excluded.
- R8: Writing 1 to status bit 2*s+n raises `req_clear[2*s+n]` for one cycle in the cycle after the write, only when `slot_present[s]` is 1. The status bit itself is not altered by the write.
- R9: A pulse on `tmo_evt[s]` sets status bit 12+s. Writing 1 to that bit clears it, and writing 0 leaves it alone. A set and a clear in the same cycle leave the bit set.
- R10: Status bits 11:8 (error flags) always read zero, and writing them has no effect.
- R11: A read strobe `ack_rd_en` on slot `ack_slot` at offset 0 (line 0) or offset 2 (line 1) raises the matching `req_clear` bit in the next cycle. It does so only when that status bit is set, the line is in level mode and the slot is present. Other offsets do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| slot_req | input | 2*NUM_SLOTS | Request levels, bit 2*s+n for slot s line n |
| slot_present | input | NUM_SLOTS | Slot populated flags |
| tmo_evt | input | NUM_SLOTS | Timeout event pulses per slot |
| ack_rd_en | input | 1 | Read strobe into a slot's interrupt space |
| ack_slot | input | SLOT_W | Slot addressed by that read |
| ack_ofs | input | ACK_OFS_W | Offset within the interrupt space |
| host_irq | output | 1 | Host interrupt line |
| req_clear | output | 2*NUM_SLOTS | One-cycle clear strobes to the module lines |

## Verification
The bench builds the block with its defaults: four slots, an 8-bit address and a 6-bit interrupt-space offset. With four slots the status word is full. Every control address is decoded, and the timeout flags occupy the top nibble. The four slot controls are set to mixed settings: level on both lines, edge plus level, one line disabled, and edge on both lines. One table can then walk pulses on top of a held level, a disabled line rising and edge lines falling. With a partial `slot_present` pattern, gated and passed strobes sit side by side in one write.

// File: rtl/slotirq_pkg.sv
package slotirq_pkg;
  localparam int WORD_W      = 16;
  localparam int CTRL_W      = 8;
  localparam int LINES       = 2;
  // register byte addresses
  localparam int OFF_REV     = 'h00;
  localparam int OFF_CTRL0   = 'h02;
  localparam int OFF_RSTWORD = 'h0A;
  localparam int OFF_STATUS  = 'h0C;
  // control bit positions
  localparam int CB_EDGE     = 4;
  localparam int CB_ENABLE   = 6;
  // status bit positions
  localparam int ST_ERR_LSB  = 8;
  localparam int ST_TMO_LSB  = 12;
endpackage

// File: rtl/slotirq_regs.sv
module slotirq_regs
  import slotirq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CTRL_W-1:0]           wdata,
  input  logic [WORD_W-1:0]           status_word,
  output logic [NUM_SLOTS*CTRL_W-1:0] ctrl_flat,
  output logic [WORD_W-1:0]           rdata,
  output logic                        status_wr
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

  logic [WORD_W-1:0] rd_val;
  logic [NUM_SLOTS-1:0] ctrl_hit;

  assign status_wr = wr_en && (addr == A_STATUS);

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_ctrl
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL0 + 2 * s);
      logic [CTRL_W-1:0] ctrl_q;
      assign ctrl_hit[s] = (addr == A_CTRL);
      always_ff @(posedge clk) begin
        if (rst) begin
          ctrl_q <= '0;
        end else if (wr_en && ctrl_hit[s]) begin
          ctrl_q <= wdata;
        end
      end
      assign ctrl_flat[s*CTRL_W +: CTRL_W] = ctrl_q;
    end
  endgenerate

  // revision, reset word and unmapped addresses all read as zero
  always_comb begin
    rd_val = '0;
    if (addr == A_STATUS) begin
      rd_val = status_word;
    end
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (ctrl_hit[i]) begin
        rd_val = {{(WORD_W-CTRL_W){1'b0}}, ctrl_flat[i*CTRL_W +: CTRL_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_en ? rd_val : '0;
    end
  end
endmodule

// File: rtl/slotirq_status.sv
module slotirq_status #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_SLOTS-1:0] req,
  input  logic [2*NUM_SLOTS-1:0] en_mask,
  input  logic [2*NUM_SLOTS-1:0] edge_mask,
  input  logic [NUM_SLOTS-1:0]   tmo_set,
  input  logic [NUM_SLOTS-1:0]   tmo_clr,
  output logic [2*NUM_SLOTS-1:0] int_q,
  output logic [NUM_SLOTS-1:0]   tmo_q,
  output logic                   host_irq
);
  logic [2*NUM_SLOTS-1:0] int_next;
  logic [2*NUM_SLOTS-1:0] rise;
  logic                   level_any;

  // enabled lines track their request; disabled lines freeze
  assign int_next  = (en_mask & req) | (~en_mask & int_q);
  assign rise      = en_mask & edge_mask & req & ~int_q;
  assign level_any = |(int_next & ~edge_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q    <= '0;
      tmo_q    <= '0;
      host_irq <= 1'b0;
    end else begin
      int_q    <= int_next;
      tmo_q    <= (tmo_q & ~tmo_clr) | tmo_set;
      host_irq <= level_any ^ (|rise);
    end
  end
endmodule

// File: rtl/slotirq_strobe.sv
module slotirq_strobe #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  parameter int ACK_OFS_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_SLOTS-1:0] w1c_bits,
  input  logic [NUM_SLOTS-1:0]   present,
  input  logic                   ack_en,
  input  logic [SLOT_W-1:0]      ack_slot,
  input  logic [ACK_OFS_W-1:0]   ack_ofs,
  input  logic [2*NUM_SLOTS-1:0] int_status,
  input  logic [2*NUM_SLOTS-1:0] edge_mask,
  output logic [2*NUM_SLOTS-1:0] clr_q
);
  logic [2*NUM_SLOTS-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < 2*NUM_SLOTS; i++) begin : g_line
      localparam int SL = i / 2;
      localparam int LN = i % 2;
      logic ack_sel;
      assign ack_sel = ack_en && (ack_slot == SLOT_W'(SL)) &&
                       (ack_ofs == ACK_OFS_W'(2 * LN));
      assign hit[i] = present[SL] &&
                      (w1c_bits[i] || (ack_sel && int_status[i] && !edge_mask[i]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q <= '0;
    end else begin
      clr_q <= hit;
    end
  end
endmodule

// File: rtl/slotirq_ctrl.sv
module slotirq_ctrl
  import slotirq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 8,
  parameter int ACK_OFS_W = 6,
  localparam int NL       = 2 * NUM_SLOTS,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  input  logic [NL-1:0]        slot_req,
  input  logic [NUM_SLOTS-1:0] slot_present,
  input  logic [NUM_SLOTS-1:0] tmo_evt,
  input  logic                 ack_rd_en,
  input  logic [SLOT_W-1:0]    ack_slot,
  input  logic [ACK_OFS_W-1:0] ack_ofs,
  output logic                 host_irq,
  output logic [NL-1:0]        req_clear
);
  logic [NUM_SLOTS*CTRL_W-1:0] ctrl_flat;
  logic [WORD_W-1:0]           status_word;
  logic                        status_wr;
  logic [NL-1:0]               en_mask, edge_mask, int_q;
  logic [NUM_SLOTS-1:0]        tmo_q;
  logic [WORD_W-1:0]           stat_wbits;
  logic                        unused_err_wr;

  assign stat_wbits    = status_wr ? reg_wdata : '0;
  assign unused_err_wr = ^stat_wbits[ST_TMO_LSB-1:NL];

  genvar i;
  generate
    for (i = 0; i < NL; i++) begin : g_mask
      assign en_mask[i]   = ctrl_flat[(i/2)*CTRL_W + CB_ENABLE + (i%2)];
      assign edge_mask[i] = ctrl_flat[(i/2)*CTRL_W + CB_EDGE + (i%2)];
    end
  endgenerate

  always_comb begin
    status_word = '0;
    status_word[NL-1:0] = int_q;
    status_word[ST_TMO_LSB +: NUM_SLOTS] = tmo_q;
  end

  slotirq_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata[CTRL_W-1:0]),
    .status_word(status_word), .ctrl_flat(ctrl_flat),
    .rdata(reg_rdata), .status_wr(status_wr)
  );

  slotirq_status #(.NUM_SLOTS(NUM_SLOTS)) u_status (
    .clk(clk), .rst(rst), .req(slot_req), .en_mask(en_mask),
    .edge_mask(edge_mask), .tmo_set(tmo_evt),
    .tmo_clr(stat_wbits[ST_TMO_LSB +: NUM_SLOTS]),
    .int_q(int_q), .tmo_q(tmo_q), .host_irq(host_irq)
  );

  slotirq_strobe #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ACK_OFS_W(ACK_OFS_W)) u_strobe (
    .clk(clk), .rst(rst), .w1c_bits(stat_wbits[NL-1:0]),
    .present(slot_present), .ack_en(ack_rd_en), .ack_slot(ack_slot),
    .ack_ofs(ack_ofs), .int_status(int_q), .edge_mask(edge_mask),
    .clr_q(req_clear)
  );
endmodule

// File: rtl/slotirq_checker.sv
module slotirq_checker #(
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   reg_wr_en,
  input logic                   reg_rd_en,
  input logic                   ack_rd_en,
  input logic [NUM_SLOTS-1:0]   slot_present,
  input logic [15:0]            reg_rdata,
  input logic                   host_irq,
  input logic [2*NUM_SLOTS-1:0] req_clear
);
  logic [2*NUM_SLOTS-1:0] pres_mask;
  genvar i;
  generate
    for (i = 0; i < 2*NUM_SLOTS; i++) begin : g_pm
      assign pres_mask[i] = slot_present[i/2];
    end
  endgenerate

  // R1: outputs quiet in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!host_irq && req_clear == '0 && reg_rdata == '0));

  // R2: read data only follows a read strobe
  a_r2_rdata_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_rd_en) |-> (reg_rdata == '0));

  // R8: no strobe reaches an empty slot
  a_r8_clear_present: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req_clear & ~$past(pres_mask)) == '0));

  // R11: a strobe is always caused by a write or an acknowledge read
  a_r11_clear_cause: assert property (@(posedge clk) disable iff (rst)
    (req_clear != '0) |-> $past(reg_wr_en || ack_rd_en));
endmodule

bind slotirq_ctrl slotirq_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .ack_rd_en(ack_rd_en), .slot_present(slot_present), .reg_rdata(reg_rdata),
  .host_irq(host_irq), .req_clear(req_clear)
);

// File: tb/tb_slotirq_ctrl.sv
module tb_slotirq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  slot_req = '0;
  logic [3:0]  slot_present = 4'hF;
  logic [3:0]  tmo_evt = '0;
  logic        ack_rd_en = 1'b0;
  logic [1:0]  ack_slot = '0;
  logic [5:0]  ack_ofs = '0;
  logic        host_irq;
  logic [7:0]  req_clear;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slotirq_ctrl dut (.*);

  // {req[7:0], irq in first cycle, held irq, status[7:0]}
  localparam logic [17:0] VEC [11] = '{
    {8'h04, 1'b1, 1'b0, 8'h04},
    {8'h05, 1'b1, 1'b1, 8'h05},
    {8'h45, 1'b0, 1'b1, 8'h45},
    {8'h41, 1'b1, 1'b1, 8'h41},
    {8'h40, 1'b0, 1'b0, 8'h40},
    {8'h60, 1'b0, 1'b0, 8'h40},
    {8'h70, 1'b1, 1'b1, 8'h50},
    {8'hF0, 1'b0, 1'b1, 8'hD0},
    {8'h00, 1'b0, 1'b0, 8'h00},
    {8'h08, 1'b1, 1'b1, 8'h08},
    {8'h00, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
    reg_rd_en = 1'b0;
  endtask

  task automatic ack(logic [1:0] s, logic [5:0] o);
    @(negedge clk);
    ack_rd_en = 1'b1; ack_slot = s; ack_ofs = o;
    @(posedge clk);
    @(negedge clk);
    ack_rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 host_irq", {15'd0, host_irq}, 16'h0);
    chk("R1 req_clear", {8'd0, req_clear}, 16'h0);
    rd(8'h0C, d); chk("R1 status", d, 16'h0000);
    rd(8'h02, d); chk("R1 ctrl A", d, 16'h0000);

    // R2 fixed and unmapped words
    wr(8'h00, 16'hFFFF); rd(8'h00, d); chk("R2 revision", d, 16'h0000);
    wr(8'h0A, 16'h1234); rd(8'h0A, d); chk("R2 reset word", d, 16'h0000);
    rd(8'h03, d); chk("R2 odd address", d, 16'h0000);
    @(negedge clk); chk("R2 idle rdata", reg_rdata, 16'h0000);

    // R3 control registers
    wr(8'h06, 16'hABCD); rd(8'h06, d); chk("R3 ctrl C readback", d, 16'h00CD);
    wr(8'h02, 16'h00C0); wr(8'h04, 16'h00D0);
    wr(8'h06, 16'h0040); wr(8'h08, 16'h00F0);
    rd(8'h04, d); chk("R3 ctrl B", d, 16'h00D0);
    rd(8'h08, d); chk("R3 ctrl D", d, 16'h00F0);

    // R4 R5 R6 R7 mixed edge/level table
    foreach (VEC[k]) begin
      @(negedge clk); slot_req = VEC[k][17:10];
      @(negedge clk);
      chk($sformatf("R6 first irq row %0d", k), {15'd0, host_irq}, {15'd0, VEC[k][9]});
      @(negedge clk);
      chk($sformatf("R7 held irq row %0d", k), {15'd0, host_irq}, {15'd0, VEC[k][8]});
      rd(8'h0C, d);
      chk($sformatf("R5 R4 status row %0d", k), d, {8'h00, VEC[k][7:0]});
    end

    // R9 timeout flags
    @(negedge clk); tmo_evt = 4'b0010;
    @(negedge clk); tmo_evt = 4'b0000;
    rd(8'h0C, d); chk("R9 timeout set", d, 16'h2000);
    wr(8'h0C, 16'h0000); rd(8'h0C, d); chk("R9 write zero keeps", d, 16'h2000);
    wr(8'h0C, 16'h2000); rd(8'h0C, d); chk("R9 w1c clears", d, 16'h0000);
    @(negedge clk);
    tmo_evt = 4'b0001; reg_wr_en = 1'b1; reg_addr = 8'h0C; reg_wdata = 16'h1000;
    @(negedge clk); tmo_evt = 4'b0000; reg_wr_en = 1'b0;
    rd(8'h0C, d); chk("R9 set wins", d, 16'h1000);
    wr(8'h0C, 16'h1000);

    // R10 error bits
    wr(8'h0C, 16'h0F00); rd(8'h0C, d); chk("R10 error bits", d, 16'h0000);
    chk("R10 no strobe", {8'd0, req_clear}, 16'h0);

    // R8 write-one-to-clear strobes
    @(negedge clk); slot_req = 8'h01;
    rd(8'h0C, d); chk("R5 A0 level", d, 16'h0001);
    slot_present = 4'b0101;
    wr(8'h0C, 16'h00FF);
    chk("R8 gated strobes", {8'd0, req_clear}, 16'h0033);
    @(negedge clk); chk("R8 one cycle", {8'd0, req_clear}, 16'h0000);
    rd(8'h0C, d); chk("R8 status untouched", d, 16'h0001);
    slot_present = 4'hF;

    // R11 acknowledge reads
    @(negedge clk); slot_req = 8'h05;
    @(negedge clk);
    ack(2'd0, 6'd0); chk("R11 ack A line0", {8'd0, req_clear}, 16'h0001);
    ack(2'd1, 6'd0); chk("R11 ack edge line", {8'd0, req_clear}, 16'h0000);
    ack(2'd0, 6'd2); chk("R11 ack clear status", {8'd0, req_clear}, 16'h0000);
    @(negedge clk); slot_req = 8'h07;
    @(negedge clk);
    ack(2'd0, 6'd2); chk("R11 ack A line1", {8'd0, req_clear}, 16'h0002);
    ack(2'd0, 6'd1); chk("R11 other offset", {8'd0, req_clear}, 16'h0000);
    slot_present = 4'b1110;
    ack(2'd0, 6'd0); chk("R11 absent slot", {8'd0, req_clear}, 16'h0000);
    slot_present = 4'hF;
    @(negedge clk); slot_req = 8'h00;

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule